// File: doc/BRIEF.md
# Addressed Serial Position Frame Receiver

This block listens on a three-wire synchronous serial link as a receive-only slave. The wires are a data line, a serial clock and an active-low select. While select is low, each rising serial clock edge shifts one data bit into a 40-bit chain. The chain holds one command byte followed by four servo position bytes. When select returns high, the upper nibble of the command byte is checked against a 4-bit address. That address comes from active-low switch inputs. If they agree, the four positions and the 4-bit time-step field are loaded into holding registers.

All three serial wires are brought into the system clock domain by two-flop synchronisers. Edges are found by comparing each synchronised value with its sample from the previous cycle. A one-cycle strobe marks every load so that downstream logic can react to new positions.

Top module: `servo_frame_rx`

## Requirements
- R1: While reset is low and right after it is released, every position field of `posOut` reads 0x80, `timeStep` reads 0, `frameBits` reads 0 and `updatePulse` is low.
- R2: A falling edge of `serSelN` clears the whole chain and sets `frameBits` to 0.
- R3: Each rising edge of `serClk` inside a frame shifts the chain right by one bit, and the sampled data bit enters command bit 7. A frame word {cmd, p1, p2, p3, p4} is therefore sent least significant bit first: p4 bit 0 goes first and cmd bit 7 goes last.
- R4: `frameBits` counts the rising `serClk` edges seen since the last falling edge of `serSelN`.
- R5: Rising `serClk` edges while `serSelN` is high change neither `frameBits` nor any held value.
- R6: On a rising edge of `serSelN`, if command bits 7:4 equal the bitwise inverse of `addrSwN`, then `timeStep` takes command bits 3:0 and positions 1 to 4 take p1 to p4. Position k appears on `posOut[8k-1:8k-8]`.
- R7: On a rising edge of `serSelN` without an address match, `posOut` and `timeStep` stay unchanged and `updatePulse` stays low.
- R8: `updatePulse` is high for exactly one system clock cycle per load. It goes high on the third rising system clock edge after the rising edge of `serSelN`, and `posOut` changes on that same edge.
- R9: A frame with fewer than 40 bits is still evaluated. The bits it carries occupy the top of the chain, and the lower positions keep the zeros written at frame start. A frame with no bits at all therefore gives address 0, time step 0 and positions of 0.
- R10: A frame with more than 40 bits keeps only the last 40 bits received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serData | input | 1 | Serial data line, asynchronous |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| serSelN | input | 1 | Active-low frame select |
| addrSwN | input | 4 | Active-low address switches |
| posOut | output | 32 | Held positions; position 1 in bits 7:0 |
| timeStep | output | 4 | Held time-step field |
| frameBits | output | 6 | Count of bits received in the current or last frame |
| updatePulse | output | 1 | One-cycle strobe when the holding registers load |

## Verification
The hardest condition to reach from the ports is a chain whose low bytes were never written during the frame. That happens in a short or empty frame, where the result depends on the clear at select fall and not on leftovers from the previous frame. The stimulus table runs a full frame first and then sends 16-bit, 8-bit and 0-bit frames. Each of these has a matching or non-matching address, so stale data would show up directly in `posOut`. A frame with eight extra leading bits, and serial clock toggles with select high, cover the overflow and ignore cases.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  // Strobes from the control side to the datapath, valid for one cycle.
  typedef struct packed {
    logic clearChain;
    logic shiftIn;
    logic commit;
    logic dataBit;
  } ctrl_cmd_t;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,          // must be 2 or more
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= {STAGES{RESET_VAL}};
    else       stageQ <= {stageQ[STAGES-2:0], asyncIn};
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   serData,
  input  logic                   serClk,
  input  logic                   serSelN,
  output sfr_pkg::ctrl_cmd_t     ctrlCmd
);
  logic [2:0] syncBus;
  logic selSync, clkSync, dataSync;
  logic prevSel, prevClk;
  logic clkRise, selFall, selRise;

  // Idle levels: select high, clock low.
  sfr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({serSelN, serClk, serData}),
    .syncOut(syncBus)
  );

  assign {selSync, clkSync, dataSync} = syncBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel <= 1'b1;
      prevClk <= 1'b0;
    end else begin
      prevSel <= selSync;
      prevClk <= clkSync;
    end
  end

  assign clkRise = clkSync & ~prevClk;
  assign selFall = ~selSync & prevSel;
  assign selRise = selSync & ~prevSel;

  always_comb begin
    ctrlCmd.clearChain = selFall;
    ctrlCmd.shiftIn    = clkRise & ~selSync;
    ctrlCmd.commit     = selRise;
    ctrlCmd.dataBit    = dataSync;
  end
endmodule

// File: rtl/sfr_datapath.sv
module sfr_datapath #(
  parameter int NUM_POS = 4,
  parameter int POS_W = 8,
  parameter int ADDR_W = 4,
  parameter int STEP_W = 4,
  parameter int CNT_W = 6,
  parameter logic [POS_W-1:0] CENTER = 8'h80
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sfr_pkg::ctrl_cmd_t       ctrlCmd,
  input  logic [ADDR_W-1:0]        addrSwN,
  output logic [NUM_POS*POS_W-1:0] posOut,
  output logic [STEP_W-1:0]        timeStep,
  output logic [CNT_W-1:0]         frameBits,
  output logic                     updatePulse
);
  localparam int CMD_W = ADDR_W + STEP_W;
  localparam int CHAIN_W = CMD_W + NUM_POS * POS_W;
  localparam int POS_TOP = CHAIN_W - CMD_W - 1;

  logic [CHAIN_W-1:0] chainQ;
  logic [CNT_W-1:0]   bitCntQ;
  logic [CMD_W-1:0]   cmdField;
  logic [ADDR_W-1:0]  addrField;
  logic               addrMatch;
  logic               loadNow;
  logic [STEP_W-1:0]  stepQ;
  logic               pulseQ;
  logic [NUM_POS-1:0][POS_W-1:0] posQ;

  // Chain: command byte on top, position 1 below it, and so on.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ  <= '0;
      bitCntQ <= '0;
    end else if (ctrlCmd.clearChain) begin
      chainQ  <= '0;
      bitCntQ <= '0;
    end else if (ctrlCmd.shiftIn) begin
      chainQ  <= {ctrlCmd.dataBit, chainQ[CHAIN_W-1:1]};
      bitCntQ <= bitCntQ + CNT_W'(1);
    end
  end

  assign cmdField  = chainQ[CHAIN_W-1 -: CMD_W];
  assign addrField = cmdField[CMD_W-1 -: ADDR_W];
  assign addrMatch = (addrField == ~addrSwN);
  assign loadNow   = ctrlCmd.commit & addrMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ  <= '0;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= loadNow;
      if (loadNow) stepQ <= cmdField[STEP_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_POS; g++) begin : g_pos
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        posQ[g] <= CENTER;
      else if (loadNow) posQ[g] <= chainQ[POS_TOP - g*POS_W -: POS_W];
    end
  end

  assign posOut      = posQ;
  assign timeStep    = stepQ;
  assign frameBits   = bitCntQ;
  assign updatePulse = pulseQ;
endmodule

// File: rtl/servo_frame_rx.sv
module servo_frame_rx #(
  parameter int NUM_POS = 4,
  parameter int POS_W = 8,
  parameter int ADDR_W = 4,
  parameter int STEP_W = 4,
  parameter int CNT_W = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [POS_W-1:0] CENTER = 8'h80
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serData,
  input  logic                     serClk,
  input  logic                     serSelN,
  input  logic [ADDR_W-1:0]        addrSwN,
  output logic [NUM_POS*POS_W-1:0] posOut,
  output logic [STEP_W-1:0]        timeStep,
  output logic [CNT_W-1:0]         frameBits,
  output logic                     updatePulse
);
  sfr_pkg::ctrl_cmd_t ctrlCmd;

  sfr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serData(serData),
    .serClk (serClk),
    .serSelN(serSelN),
    .ctrlCmd(ctrlCmd)
  );

  sfr_datapath #(
    .NUM_POS(NUM_POS), .POS_W(POS_W), .ADDR_W(ADDR_W),
    .STEP_W(STEP_W), .CNT_W(CNT_W), .CENTER(CENTER)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlCmd    (ctrlCmd),
    .addrSwN    (addrSwN),
    .posOut     (posOut),
    .timeStep   (timeStep),
    .frameBits  (frameBits),
    .updatePulse(updatePulse)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int NUM_POS = 4,
  parameter int POS_W = 8,
  parameter int STEP_W = 4,
  parameter int CNT_W = 6,
  parameter logic [POS_W-1:0] CENTER = 8'h80
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_POS*POS_W-1:0] posOut,
  input logic [STEP_W-1:0]        timeStep,
  input logic [CNT_W-1:0]         frameBits,
  input logic                     updatePulse,
  input logic                     clearStb,
  input logic                     shiftStb,
  input logic                     commitStb
);
  localparam logic [NUM_POS*POS_W-1:0] CENTER_ALL = {NUM_POS{CENTER}};

  p_reset_center_r1: assert property (@(posedge clk)
    !rstN |=> (posOut == CENTER_ALL && timeStep == '0 && !updatePulse));

  p_clear_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> frameBits == '0);

  p_shift_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (shiftStb && !clearStb) |=> frameBits == $past(frameBits) + CNT_W'(1));

  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftStb && !clearStb) |=> $stable(frameBits));

  p_hold_no_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    !updatePulse |-> ($stable(posOut) && $stable(timeStep)));

  p_pulse_after_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |-> $past(commitStb));

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |=> !updatePulse);
endmodule

bind servo_frame_rx sfr_checker #(
  .NUM_POS(NUM_POS), .POS_W(POS_W), .STEP_W(STEP_W), .CNT_W(CNT_W), .CENTER(CENTER)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .posOut     (posOut),
  .timeStep   (timeStep),
  .frameBits  (frameBits),
  .updatePulse(updatePulse),
  .clearStb   (ctrlCmd.clearChain),
  .shiftStb   (ctrlCmd.shiftIn),
  .commitStb  (ctrlCmd.commit)
);

// File: tb/servo_frame_rx_bench.sv
module servo_frame_rx_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serData = 1'b0;
  logic serClk = 1'b0;
  logic serSelN = 1'b1;
  logic [3:0] addrSwN = 4'hF;
  logic [31:0] posOut;
  logic [3:0] timeStep;
  logic [5:0] frameBits;
  logic updatePulse;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] expPos = 32'h8080_8080;
  logic [3:0] expStep = 4'h0;

  always #5 clk = ~clk;

  servo_frame_rx u_servo_frame_rx (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .serSelN(serSelN), .addrSwN(addrSwN), .posOut(posOut),
    .timeStep(timeStep), .frameBits(frameBits), .updatePulse(updatePulse)
  );

  localparam int NVEC = 7;
  localparam logic [3:0] VEC_SW [NVEC] = '{4'b1010, 4'b1010, 4'b0000, 4'b1111,
                                           4'b0101, 4'b0101, 4'b1111};
  localparam logic [39:0] VEC_WORD [NVEC] = '{
    40'h57_11_22_33_44, 40'h63_AA_BB_CC_DD, 40'hF0_00_FF_01_FE,
    40'h0F_12_80_7F_E5, 40'h00_00_00_A9_3C, 40'h00_00_00_00_5E,
    40'h00_00_00_00_00};
  localparam int VEC_BITS [NVEC] = '{40, 40, 40, 40, 16, 8, 0};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic sendBits(input logic [39:0] word, input int n);
    for (int i = 0; i < n; i++) begin
      serData = word[i];
      tick(2);
      serClk = 1'b1;
      tick(4);
      serClk = 1'b0;
      tick(2);
    end
  endtask

  // Full frame: optional leading junk bits, then n bits of word, LSB first.
  task automatic doFrame(input logic [3:0] sw, input logic [39:0] word, input int n,
                         input logic [39:0] junk, input int nJunk);
    logic [39:0] chain;
    logic match;
    addrSwN = sw;
    serSelN = 1'b0;
    tick(4);
    check("R2 count cleared at frame start", 64'(frameBits), 64'd0);
    sendBits(junk, nJunk);
    sendBits(word, n);
    check("R4 bit count", 64'(frameBits), 64'(n + nJunk));
    if (n >= 40) chain = word;
    else chain = (word & ((40'd1 << n) - 40'd1)) << (40 - n);
    match = (chain[39:36] == ~sw);
    serSelN = 1'b1;
    tick(2);
    check("R8 no pulse before third edge", 64'(updatePulse), 64'd0);
    tick(1);
    check("R8 pulse on third edge", 64'(updatePulse), 64'(match));
    if (match) begin
      expStep = chain[35:32];
      expPos  = {chain[7:0], chain[15:8], chain[23:16], chain[31:24]};
    end
    check(match ? "R6 positions loaded" : "R7 positions held", 64'(posOut), 64'(expPos));
    check(match ? "R6 time step loaded" : "R7 time step held", 64'(timeStep), 64'(expStep));
    tick(1);
    check("R8 pulse lasts one cycle", 64'(updatePulse), 64'd0);
    tick(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    tick(3);
    check("R1 positions in reset", 64'(posOut), 64'h8080_8080);
    rstN = 1'b1;
    tick(2);
    check("R1 positions after reset", 64'(posOut), 64'h8080_8080);
    check("R1 time step after reset", 64'(timeStep), 64'd0);
    check("R1 count after reset", 64'(frameBits), 64'd0);
    check("R1 no pulse after reset", 64'(updatePulse), 64'd0);

    // Table of frames: R3 byte order, R6/R7 address, R9 short and empty frames
    for (int v = 0; v < NVEC; v++) begin
      doFrame(VEC_SW[v], VEC_WORD[v], VEC_BITS[v], 40'h0, 0);
      if (v == 0) begin
        check("R3 position 1 field", 64'(posOut[7:0]), 64'h11);
        check("R3 position 4 field", 64'(posOut[31:24]), 64'h44);
      end
    end

    // R5: serial clock with select high changes nothing
    doFrame(4'b1100, 40'h3B_01_02_03_04, 40, 40'h0, 0);
    for (int k = 0; k < 3; k++) begin
      serData = ~serData;
      serClk = 1'b1;
      tick(4);
      serClk = 1'b0;
      tick(4);
      check("R5 no pulse with select high", 64'(updatePulse), 64'd0);
    end
    check("R5 count held with select high", 64'(frameBits), 64'd40);
    check("R5 positions held with select high", 64'(posOut), 64'h0403_0201);

    // R10: eight extra leading bits are pushed out of the chain
    doFrame(4'b0110, 40'h98_C1_C2_C3_C4, 40, 40'hFF, 8);
    check("R10 last 40 bits kept", 64'(posOut), 64'hC4C3_C2C1);
    check("R10 time step", 64'(timeStep), 64'h8);

    finishRun();
  end
endmodule